// File: doc/BRIEF.md
# Byte-Serial Link Port with Word Packing

This block is one end of a point-to-point link that carries words over an 8-bit data path. A one-cycle link strobe marks each byte, and an acknowledge line running the other way gives flow control. Set for transmit, it takes words from a valid/ready word interface and sends them least-significant byte first. Set for receive, it rebuilds words from the incoming bytes and offers them on a second valid/ready interface. Words are either 32 bits wide (four bytes) or 48 bits wide (six bytes).

Each direction has two storage stages. The transmitter has a holding register and a shift register. The receiver has an assembly register and a holding register. So the word side can hand over or collect the next word while the link is still busy with the current one. On the receive side, acknowledge is withdrawn early enough that a sender which reacts to it one cycle late never overruns the assembly register.

Direction and width are set through `cfg_tx` and `cfg_wide`. They may only change while reset is asserted.

Top module: `link_port`

## Requirements
- R1: During and just after reset, `lk_clk_out` and `rx_valid` are 0. In transmit mode (`cfg_tx`=1), `tx_ready` is 1 and `lk_ack_out` is 0. In receive mode (`cfg_tx`=0), `lk_ack_out` is 1 and `tx_ready` is 0.
- R2: With `cfg_wide`=0, each accepted word leaves as four strobed bytes on `lk_dout`, bits 7:0 first and bits 31:24 last. Bits 47:32 of `tx_word` are never sent.
- R3: With `cfg_wide`=1, each accepted word leaves as six strobed bytes, bits 7:0 first and bits 47:40 last.
- R4: `lk_clk_out` is high in a cycle only if `lk_ack_in` was high in the cycle before it.
- R5: The transmitter never stops partway through a word unless acknowledge is withdrawn. When its holding register is empty it stops at a word boundary. When the next word is already held and `lk_ack_in` stays high, the first byte of the next word follows the last byte of the current word with no idle cycle.
- R6: `tx_ready` is high whenever the transmit holding register is empty. A new word can therefore be accepted while earlier bytes are still waiting to be sent.
- R7: In receive mode, the k-th byte of a word lands in bits 8k+7:8k of `rx_word`. With `cfg_wide`=0, bits 47:32 of `rx_word` are 0.
- R8: In receive mode, let U be the number of received bytes not yet removed by an `rx_valid`/`rx_ready` handshake, and n the word size in bytes. `lk_ack_out` is low exactly when U ≥ 2n−1.
- R9: `rx_valid` is high exactly when U ≥ n. A sender that reacts to `lk_ack_out` one cycle late loses no byte, and words come out in arrival order.
- R10: Once `rx_valid` is high, it and `rx_word` hold steady until a cycle with `rx_ready` high.
- R11: In receive mode, `lk_clk_out` and `tx_ready` stay 0 whatever `tx_valid` does. In transmit mode, `lk_ack_out` and `rx_valid` stay 0 and strobes on `lk_clk_in` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the block and the link |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tx | input | 1 | 1 = transmit, 0 = receive |
| cfg_wide | input | 1 | 1 = 48-bit words, 0 = 32-bit words |
| tx_word | input | 48 | Word to send |
| tx_valid | input | 1 | `tx_word` is offered |
| tx_ready | output | 1 | Transmit holding register is empty |
| rx_word | output | 48 | Rebuilt word |
| rx_valid | output | 1 | `rx_word` is available |
| rx_ready | input | 1 | Word side takes `rx_word` |
| lk_dout | output | 8 | Outgoing link byte |
| lk_clk_out | output | 1 | Outgoing byte strobe |
| lk_ack_in | input | 1 | Acknowledge from the far receiver |
| lk_din | input | 8 | Incoming link byte |
| lk_clk_in | input | 1 | Incoming byte strobe |
| lk_ack_out | output | 1 | Acknowledge to the far transmitter |

## Verification
On the receive side, the arrival of a byte that completes a word can fall in the same cycle as the word side draining the holding register. The completed word must then go straight into the register being emptied. The bench provokes this by sending a continuous byte stream while `rx_ready` is held low for a long stretch and then toggled every third cycle. Every cycle it compares `lk_ack_out` and `rx_valid` with its count of unread bytes, and it compares each drained word against its own queue. On the transmit side, the last byte of a word coincides with the reload of the shift register from the holding register. This is judged by requiring an unbroken run of strobes across word boundaries when acknowledge stays high.

// File: rtl/lp_pkg.sv
package lp_pkg;
  typedef enum logic {LP_RX = 1'b0, LP_TX = 1'b1} lp_dir_e;

  function automatic int unsigned lp_word_bytes(input logic wide,
                                                input int unsigned narrow_n,
                                                input int unsigned full_n);
    return wide ? full_n : narrow_n;
  endfunction
endpackage

// File: rtl/lp_tx.sv
module lp_tx #(
  parameter int BYTE_W       = 8,
  parameter int MAX_BYTES    = 6,
  parameter int NARROW_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        wide,
  input  logic [BYTE_W*MAX_BYTES-1:0] word_data,
  input  logic                        word_valid,
  output logic                        word_ready,
  input  logic                        ack_in,
  output logic                        byte_stb,
  output logic [BYTE_W-1:0]           byte_data,
  output logic                        ev_load
);
  import lp_pkg::*;
  localparam int WORD_W = BYTE_W * MAX_BYTES;
  localparam int CW     = $clog2(MAX_BYTES + 1);

  logic [WORD_W-1:0] hold_q, sh_q;
  logic              hold_v;
  logic [CW-1:0]     left_q;
  logic              stb_q;
  logic [BYTE_W-1:0] dat_q;
  logic [CW-1:0]     need;
  logic              push, send, reload;

  assign need       = CW'(lp_word_bytes(wide, NARROW_BYTES, MAX_BYTES));
  assign word_ready = en && !hold_v;
  assign push       = word_valid && word_ready;
  assign send       = en && (left_q != '0) && ack_in;
  // refill the shifter when it is idle, or as its last byte leaves
  assign reload     = hold_v && ((left_q == '0) || (send && left_q == CW'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= '0;
      hold_v <= 1'b0;
      sh_q   <= '0;
      left_q <= '0;
      stb_q  <= 1'b0;
      dat_q  <= '0;
    end else begin
      stb_q <= send;
      if (send) dat_q <= sh_q[BYTE_W-1:0];
      if (reload) begin
        sh_q   <= hold_q;
        left_q <= need;
        hold_v <= 1'b0;
      end else if (send) begin
        sh_q   <= sh_q >> BYTE_W;
        left_q <= left_q - CW'(1);
      end
      if (push) begin
        hold_q <= word_data;
        hold_v <= 1'b1;
      end
    end
  end

  assign byte_stb  = stb_q;
  assign byte_data = dat_q;
  assign ev_load   = reload;
endmodule

// File: rtl/lp_rx.sv
module lp_rx #(
  parameter int BYTE_W       = 8,
  parameter int MAX_BYTES    = 6,
  parameter int NARROW_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        wide,
  input  logic                        byte_stb,
  input  logic [BYTE_W-1:0]           byte_data,
  output logic                        ack_out,
  output logic [BYTE_W*MAX_BYTES-1:0] word_data,
  output logic                        word_valid,
  input  logic                        word_ready,
  output logic                        ev_overrun
);
  import lp_pkg::*;
  localparam int WORD_W = BYTE_W * MAX_BYTES;
  localparam int CW     = $clog2(MAX_BYTES + 1);

  function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                 input logic [CW-1:0]     idx,
                                                 input logic [BYTE_W-1:0] b);
    logic [WORD_W-1:0] r;
    r = w;
    for (int k = 0; k < MAX_BYTES; k++)
      if (idx == CW'(k)) r[k*BYTE_W +: BYTE_W] = b;
    return r;
  endfunction

  logic [WORD_W-1:0] asm_q, hold_q, merged;
  logic [CW-1:0]     cnt_q, need;
  logic              hold_v;
  logic              byte_in, asm_full, completing, pop, hold_free;

  assign need       = CW'(lp_word_bytes(wide, NARROW_BYTES, MAX_BYTES));
  assign byte_in    = en && byte_stb;
  assign asm_full   = (cnt_q == need);
  assign completing = byte_in && (cnt_q == need - CW'(1));
  assign pop        = hold_v && word_ready;
  assign hold_free  = !hold_v || pop;
  assign merged     = put_byte(asm_q, cnt_q, byte_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asm_q  <= '0;
      hold_q <= '0;
      cnt_q  <= '0;
      hold_v <= 1'b0;
    end else begin
      if (pop) hold_v <= 1'b0;
      if (completing && hold_free) begin
        hold_q <= merged;
        hold_v <= 1'b1;
        asm_q  <= '0;
        cnt_q  <= '0;
      end else if (asm_full && hold_free) begin
        hold_q <= asm_q;
        hold_v <= 1'b1;
        asm_q  <= '0;
        cnt_q  <= '0;
      end else if (byte_in && !asm_full) begin
        asm_q <= merged;
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // withdraw one byte early: the far sender may already have one in flight
  assign ack_out    = en && !(hold_v && (cnt_q >= need - CW'(1)));
  assign word_data  = hold_q;
  assign word_valid = hold_v;
  assign ev_overrun = byte_in && asm_full;
endmodule

// File: rtl/link_port.sv
module link_port #(
  parameter int BYTE_W       = 8,
  parameter int MAX_BYTES    = 6,
  parameter int NARROW_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_tx,
  input  logic                        cfg_wide,
  input  logic [BYTE_W*MAX_BYTES-1:0] tx_word,
  input  logic                        tx_valid,
  output logic                        tx_ready,
  output logic [BYTE_W*MAX_BYTES-1:0] rx_word,
  output logic                        rx_valid,
  input  logic                        rx_ready,
  output logic [BYTE_W-1:0]           lk_dout,
  output logic                        lk_clk_out,
  input  logic                        lk_ack_in,
  input  logic [BYTE_W-1:0]           lk_din,
  input  logic                        lk_clk_in,
  output logic                        lk_ack_out
);
  import lp_pkg::*;

  lp_dir_e dir;
  logic    tx_en, rx_en;
  logic    ev_tx_load, ev_rx_overrun;

  assign dir   = lp_dir_e'(cfg_tx);
  assign tx_en = (dir == LP_TX);
  assign rx_en = (dir == LP_RX);

  lp_tx #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .NARROW_BYTES(NARROW_BYTES)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .wide(cfg_wide),
    .word_data(tx_word), .word_valid(tx_valid), .word_ready(tx_ready),
    .ack_in(lk_ack_in), .byte_stb(lk_clk_out), .byte_data(lk_dout),
    .ev_load(ev_tx_load)
  );

  lp_rx #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .NARROW_BYTES(NARROW_BYTES)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .wide(cfg_wide),
    .byte_stb(lk_clk_in), .byte_data(lk_din), .ack_out(lk_ack_out),
    .word_data(rx_word), .word_valid(rx_valid), .word_ready(rx_ready),
    .ev_overrun(ev_rx_overrun)
  );
endmodule

// File: rtl/lp_checker.sv
module lp_checker #(
  parameter int BYTE_W       = 8,
  parameter int MAX_BYTES    = 6,
  parameter int NARROW_BYTES = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cfg_tx,
  input logic                        cfg_wide,
  input logic                        tx_ready,
  input logic [BYTE_W*MAX_BYTES-1:0] rx_word,
  input logic                        rx_valid,
  input logic                        rx_ready,
  input logic                        lk_clk_out,
  input logic                        lk_ack_in,
  input logic                        lk_ack_out,
  input logic                        ev_tx_load,
  input logic                        ev_rx_overrun
);
  localparam int WORD_W = BYTE_W * MAX_BYTES;
  localparam int LOW_W  = BYTE_W * NARROW_BYTES;

  assert_strobe_needs_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lk_clk_out |-> $past(lk_ack_in));

  assert_load_frees_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_load |=> tx_ready);

  assert_narrow_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_wide) |-> (rx_word[WORD_W-1:LOW_W] == '0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_rx_overrun);

  assert_word_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_word)));

  assert_tx_mode_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_tx |-> (!rx_valid && !lk_ack_out));

  assert_rx_mode_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_tx |-> (!lk_clk_out && !tx_ready));
endmodule

bind link_port lp_checker #(.BYTE_W(BYTE_W), .MAX_BYTES(MAX_BYTES), .NARROW_BYTES(NARROW_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_tx(cfg_tx), .cfg_wide(cfg_wide),
  .tx_ready(tx_ready), .rx_word(rx_word), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .lk_clk_out(lk_clk_out), .lk_ack_in(lk_ack_in), .lk_ack_out(lk_ack_out),
  .ev_tx_load(ev_tx_load), .ev_rx_overrun(ev_rx_overrun)
);

// File: tb/sim_link_port.sv
module sim_link_port;
  localparam int WW = 48;

  logic          clk = 1'b0, rst_n = 1'b0, cfg_tx = 1'b0, cfg_wide = 1'b0;
  logic [WW-1:0] tx_word = '0;
  logic          tx_valid = 1'b0, rx_ready = 1'b0, lk_ack_in = 1'b0, lk_clk_in = 1'b0;
  logic [7:0]    lk_din = '0;
  logic          tx_ready, rx_valid, lk_clk_out, lk_ack_out;
  logic [WW-1:0] rx_word;
  logic [7:0]    lk_dout;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  link_port u0 (
    .clk(clk), .rst_n(rst_n), .cfg_tx(cfg_tx), .cfg_wide(cfg_wide),
    .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_word(rx_word), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .lk_dout(lk_dout), .lk_clk_out(lk_clk_out), .lk_ack_in(lk_ack_in),
    .lk_din(lk_din), .lk_clk_in(lk_clk_in), .lk_ack_out(lk_ack_out)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] mkword(input int k);
    return (48'h1357_9BDF_2468 * 48'(k + 1)) ^ 48'hF0E1_D2C3_B4A5;
  endfunction

  task automatic do_reset(input bit tx, input bit wide);
    rst_n = 1'b0; cfg_tx = tx; cfg_wide = wide;
    tx_valid = 0; rx_ready = 0; lk_ack_in = 0; lk_clk_in = 0; lk_din = '0; tx_word = '0;
    repeat (3) @(negedge clk);
    check(!lk_clk_out && !rx_valid, "R1 strobe/valid in reset", {lk_clk_out, rx_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!lk_clk_out && !rx_valid, "R1 strobe/valid after reset", {lk_clk_out, rx_valid}, 0);
    check(tx_ready == tx, "R1 tx_ready after reset", tx_ready, tx);
    check(lk_ack_out == !tx, "R1 lk_ack_out after reset", lk_ack_out, !tx);
  endtask

  // transmit: the bench is the far receiver
  task automatic tx_run(input bit wide, input int nwords, input int ack_mode, input int gap, input int seed);
    logic [7:0] expq[$];
    int n = wide ? 6 : 4;
    int k = 0, strobes = 0, first = -1, last = -1, run = 0;
    bit prev_ack = 0, busy_accept = 0, ack;
    string tg = wide ? "R3" : "R2";
    int limit = nwords * n * 4 + gap * nwords + 40;
    for (int cyc = 0; cyc < limit; cyc++) begin
      @(negedge clk);
      if (lk_clk_out) begin
        strobes++; run++;
        if (first < 0) first = cyc;
        last = cyc;
        check(prev_ack, "R4 strobe without prior ack", lk_clk_out, 0);
        if (expq.size() == 0) check(0, "R5 byte beyond accepted words", lk_dout, 0);
        else begin
          logic [7:0] e = expq.pop_front();
          check(lk_dout == e, {tg, " byte order"}, lk_dout, e);
        end
      end else if (run > 0) begin
        if (gap > 0) check(run == n, "R5 burst is one whole word", run, n);
        run = 0;
      end
      tx_valid = (k < nwords) && (gap == 0 || cyc % gap == 0);
      tx_word  = mkword(k + seed);
      if (tx_valid && tx_ready) begin
        if (expq.size() > 0) busy_accept = 1;
        for (int b = 0; b < n; b++) expq.push_back(tx_word[8*b +: 8]);
        k++;
      end
      case (ack_mode)
        0:       ack = 1'b1;
        default: ack = (cyc % 5 != 2) && (cyc % 13 < 9);
      endcase
      lk_ack_in = ack;
      prev_ack  = ack;
    end
    tx_valid = 0;
    check(expq.size() == 0, "R5 all bytes of accepted words sent", expq.size(), 0);
    check(strobes == nwords * n, {tg, " byte count"}, strobes, nwords * n);
    if (ack_mode == 0 && gap == 0) begin
      check(last - first + 1 == nwords * n, "R5 no idle between held words", last - first + 1, nwords * n);
      check(busy_accept, "R6 word accepted while link busy", busy_accept, 1);
    end
  endtask

  // receive: the bench is the far transmitter, reacting to ack one cycle late
  task automatic rx_run(input bit wide, input int nwords, input int ready_mode, input int seed);
    logic [7:0]    txq[$];
    logic [WW-1:0] expw[$];
    logic [WW-1:0] prev_word = '0;
    int n = wide ? 6 : 4;
    int consumed = 0, popped = 0, u;
    bit stb_next = 0, last_stb = 0, last_pop = 0, prev_hold = 0;
    int limit = nwords * n * 4 + 140;
    for (int w = 0; w < nwords; w++) begin
      logic [WW-1:0] wd = mkword(w + seed);
      logic [WW-1:0] ex = '0;
      for (int b = 0; b < n; b++) begin
        txq.push_back(wd[8*b +: 8]);
        ex[8*b +: 8] = wd[8*b +: 8];
      end
      expw.push_back(ex);
    end
    for (int cyc = 0; cyc < limit; cyc++) begin
      @(negedge clk);
      if (last_stb) consumed++;
      if (last_pop) popped++;
      u = consumed - popped * n;
      check(lk_ack_out == (u < 2*n - 1), "R8 ack versus unread bytes", lk_ack_out, (u < 2*n - 1));
      check(rx_valid == (u >= n), "R9 valid versus unread bytes", rx_valid, (u >= n));
      if (prev_hold)
        check(rx_valid && rx_word == prev_word, "R10 word held until taken", rx_word, prev_word);
      lk_clk_in = stb_next;
      if (stb_next) lk_din = txq.pop_front();
      last_stb = stb_next;
      stb_next = lk_ack_out && (txq.size() > 0);
      if (ready_mode == 0) rx_ready = 1'b1;
      else rx_ready = (cyc >= 60) && (cyc % 3 == 0);
      last_pop = rx_valid && rx_ready;
      if (last_pop) begin
        if (expw.size() == 0) check(0, "R9 extra word", rx_word, 0);
        else begin
          logic [WW-1:0] e = expw.pop_front();
          check(rx_word == e, "R7 assembled word", rx_word, e);
        end
      end
      prev_hold = rx_valid && !rx_ready;
      prev_word = rx_word;
    end
    @(negedge clk);
    lk_clk_in = 0; rx_ready = 0;
    check(expw.size() == 0, "R9 all words delivered", expw.size(), 0);
    check(txq.size() == 0, "R9 all bytes accepted", txq.size(), 0);
  endtask

  initial begin
    do_reset(1, 0);
    tx_run(0, 6, 0, 0, 0);
    tx_run(0, 5, 1, 0, 10);
    do_reset(1, 1);
    tx_run(1, 6, 0, 0, 20);
    tx_run(1, 4, 0, 20, 30);
    tx_run(1, 5, 1, 0, 40);
    // R11: link input strobes ignored in transmit mode
    rx_ready = 1;
    for (int i = 0; i < 12; i++) begin
      lk_clk_in = 1; lk_din = 8'(i * 37);
      @(negedge clk);
      check(!rx_valid && !lk_ack_out, "R11 receive side quiet in transmit mode", {rx_valid, lk_ack_out}, 0);
    end
    lk_clk_in = 0; rx_ready = 0;
    do_reset(0, 0);
    rx_run(0, 8, 0, 50);
    rx_run(0, 10, 1, 60);
    // R11: word offers ignored in receive mode
    lk_ack_in = 1; tx_valid = 1; tx_word = mkword(99);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(!tx_ready && !lk_clk_out, "R11 transmit side quiet in receive mode", {tx_ready, lk_clk_out}, 0);
    end
    tx_valid = 0; lk_ack_in = 0;
    do_reset(0, 1);
    rx_run(1, 8, 0, 70);
    rx_run(1, 10, 1, 80);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule